// File: doc/BRIEF.md
# Bus-Master DMA Channel Status and Descriptor Pointer Registers

This block holds the software-visible state of one channel of a bus-master disk DMA engine. It has an 8-bit status register and a 32-bit pointer to the start of the descriptor table. Both sit in a small I/O window, and software reaches them through a dword-wide register port with byte enables. The DMA engine sends single-cycle event pulses into the block. The block turns them into sticky flags, keeps an activity flag that tracks the start bit, and drives an interrupt line.

The status register mixes three kinds of bit:
- flags that software clears by writing 1,
- two capability bits that software owns outright,
- an activity bit that only hardware can change.

The pointer keeps address bits 31:2 and always reads 00 in bits 1:0. Software must place the descriptor table on a dword boundary and must not let it run across a 64 KB boundary. The block stores the address as written and does not check that rule.

Top module: `dma_chan_status_regs`

## Requirements
- R1: Status bit 7 (descriptor-interrupt flag) becomes 1 on the clock after `ev_desc_irq`. A status write with bit 7 of the status byte at 1 clears it.
- R2: Status bits 6 and 5 (drive 1 and drive 0 DMA-capable) take the written value on every status write. No event input ever changes them.
- R3: Status bits 4:3 always read 0, whatever is written.
- R4: Status bit 2 (device-interrupt flag) becomes 1 on the clock after `ev_dev_irq_frame` while `dev_irq_disable` is low. When `dev_irq_disable` is high the frame has no effect. The flag clears when bit 2 is written as 1.
- R5: Status bit 1 (bus-error flag) becomes 1 on the clock after `ev_bus_abort`. It clears when bit 1 is written as 1.
- R6: Status bit 0 (active) is changed only by events, never by writes:
  - `ev_start_clr` clears it and wins over `ev_start_set`;
  - otherwise `ev_start_set` sets it and wins over `ev_eot`;
  - otherwise `ev_eot` clears it.
- R7: After reset the status register reads 00h. With the default parameters the pointer reads 0.
- R8: The pointer sits in dword 1 (byte offset 04h). Each byte lane of bits 31:2 is written only when its `reg_be` bit is set. Bits 1:0 always read 0.
- R9: If a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends at 1. Writing 0 to a flag bit leaves it unchanged.
- R10: `irq_o` is high exactly when status bit 7 or status bit 2 is 1.
- R11: The status register sits in byte lane 2 of dword 0 (byte offset 02h). A status write needs `reg_be[2]`.
  - A read of dword 0 returns the status in bits 23:16 and 0 elsewhere.
  - A read of dword 1 returns the pointer.
  - A read of any other dword returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address in the window; bits ADDR_W-1:2 select the dword |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed dword (combinational) |
| ev_desc_irq | input | 1 | A descriptor with its interrupt-request bit set has completed |
| ev_eot | input | 1 | The last transfer of the end-of-table region has completed |
| ev_bus_abort | input | 1 | A bus transfer ended in a target or master abort |
| ev_dev_irq_frame | input | 1 | A device frame with its interrupt bit set has arrived |
| dev_irq_disable | input | 1 | Device-side interrupt disable |
| ev_start_set | input | 1 | Software wrote the start bit to 1 |
| ev_start_clr | input | 1 | Software cleared the start bit |
| status_o | output | 8 | Status register contents |
| desc_ptr_o | output | 32 | Descriptor pointer contents |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives set events and write-1 clears of the same flag in the same cycle. A design that gives the clear priority loses the event, and the flag reads 0 where it should read 1. Status writes with the flag bits at 0 expose a design that treats every write as a clear. Writes to bit 0, and `ev_start_set` together with `ev_eot`, reveal an activity bit that software can touch or that uses the wrong priority. Partial byte-enable writes to the pointer, writes with `reg_be[2]` low to dword 0, and device frames while interrupts are disabled each show up as a wrong byte or a wrong flag in the reference comparison made every cycle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   localparam int REG_W     = 32;
   localparam int LANES     = REG_W / 8;
   localparam int STAT_LANE = 2;
   localparam int STAT_W    = 8;

   // status bit positions (software decodes these)
   localparam int B_DESC_IRQ = 7;
   localparam int B_CAP1     = 6;
   localparam int B_CAP0     = 5;
   localparam int B_DEV_IRQ  = 2;
   localparam int B_BUS_ERR  = 1;
   localparam int B_ACTIVE   = 0;

   // write-one-to-clear flags, indexed 0..N_FLAGS-1
   localparam int N_FLAGS = 3;

   function automatic int flag_pos(input int idx);
      case (idx)
         0:       return B_DESC_IRQ;
         1:       return B_DEV_IRQ;
         default: return B_BUS_ERR;
      endcase
   endfunction

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2
   } act_op_e;
endpackage

// File: rtl/dcs_w1c_flag.sv
module dcs_w1c_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set has priority so that no event is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/dcs_status_reg.sv
module dcs_status_reg
   import dcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [STAT_W-1:0] wdata_i,
   input  logic              ev_desc_irq_i,
   input  logic              ev_dev_frame_i,
   input  logic              dev_irq_dis_i,
   input  logic              ev_abort_i,
   input  logic              ev_start_set_i,
   input  logic              ev_start_clr_i,
   input  logic              ev_eot_i,
   output logic [STAT_W-1:0] stat_o
);
   logic [N_FLAGS-1:0] flag_set;
   logic [N_FLAGS-1:0] flag_clr;
   logic [N_FLAGS-1:0] flag_q;
   logic [1:0]         cap_q;
   logic               act_q;
   act_op_e            act_op;

   assign flag_set[0] = ev_desc_irq_i;
   assign flag_set[1] = ev_dev_frame_i & ~dev_irq_dis_i;
   assign flag_set[2] = ev_abort_i;

   for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      localparam int POS = flag_pos(i);
      assign flag_clr[i] = wr_i & wdata_i[POS];
      dcs_w1c_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (flag_set[i]),
         .clr_i (flag_clr[i]),
         .q_o   (flag_q[i])
      );
   end

   // software-owned capability bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cap_q <= 2'b00;
      else if (wr_i) cap_q <= {wdata_i[B_CAP1], wdata_i[B_CAP0]};
   end

   // activity bit: start clear > start set > end of table
   always_comb begin
      if (ev_start_clr_i)      act_op = ACT_CLR;
      else if (ev_start_set_i) act_op = ACT_SET;
      else if (ev_eot_i)       act_op = ACT_CLR;
      else                     act_op = ACT_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else begin
         case (act_op)
            ACT_SET: act_q <= 1'b1;
            ACT_CLR: act_q <= 1'b0;
            default: act_q <= act_q;
         endcase
      end
   end

   always_comb begin
      stat_o             = '0;
      stat_o[B_DESC_IRQ] = flag_q[0];
      stat_o[B_DEV_IRQ]  = flag_q[1];
      stat_o[B_BUS_ERR]  = flag_q[2];
      stat_o[B_CAP1]     = cap_q[1];
      stat_o[B_CAP0]     = cap_q[0];
      stat_o[B_ACTIVE]   = act_q;
   end
endmodule

// File: rtl/dcs_desc_ptr.sv
module dcs_desc_ptr
   import dcs_pkg::*;
#(
   parameter int W          = REG_W,
   parameter bit RESET_ZERO = 1'b1,
   localparam int NL        = W / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [NL-1:0] be_i,
   input  logic [W-1:0]  wdata_i,
   output logic [W-1:0]  ptr_o
);
   for (genvar l = 0; l < NL; l++) begin : g_lane
      localparam logic [7:0] MASK = (l == 0) ? 8'hFC : 8'hFF;
      logic [7:0] lane_q;
      logic       lane_we;
      assign lane_we = wr_i & be_i[l];

      if (RESET_ZERO) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lane_q <= 8'h00;
            else if (lane_we) lane_q <= wdata_i[l*8 +: 8] & MASK;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (lane_we) lane_q <= wdata_i[l*8 +: 8] & MASK;
         end
      end

      assign ptr_o[l*8 +: 8] = lane_q;
   end
endmodule

// File: rtl/dma_chan_status_regs.sv
module dma_chan_status_regs
   import dcs_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int STAT_DWORD     = 0,
   parameter int PTR_DWORD      = 1,
   parameter bit PTR_RESET_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [LANES-1:0]  reg_be,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              ev_desc_irq,
   input  logic              ev_eot,
   input  logic              ev_bus_abort,
   input  logic              ev_dev_irq_frame,
   input  logic              dev_irq_disable,
   input  logic              ev_start_set,
   input  logic              ev_start_clr,
   output logic [STAT_W-1:0] status_o,
   output logic [REG_W-1:0]  desc_ptr_o,
   output logic              irq_o
);
   localparam int DW_BITS = ADDR_W - 2;
   localparam int N_DW    = 1 << DW_BITS;

   if (ADDR_W < 3) begin : g_chk_aw
      $error("ADDR_W must leave room for at least two dwords");
   end
   if (STAT_DWORD == PTR_DWORD) begin : g_chk_dist
      $error("status and pointer dwords must differ");
   end
   if (STAT_DWORD >= N_DW || PTR_DWORD >= N_DW) begin : g_chk_rng
      $error("register dword outside the window");
   end

   logic [DW_BITS-1:0] dw_idx;
   logic               hit_stat;
   logic               hit_ptr;
   logic               stat_wr;
   logic [STAT_W-1:0]  stat_q;
   logic [REG_W-1:0]   ptr_q;

   assign dw_idx   = reg_addr[ADDR_W-1:2];
   assign hit_stat = (dw_idx == DW_BITS'(STAT_DWORD));
   assign hit_ptr  = (dw_idx == DW_BITS'(PTR_DWORD));
   assign stat_wr  = reg_wr & hit_stat & reg_be[STAT_LANE];

   dcs_status_reg u_stat (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_i           (stat_wr),
      .wdata_i        (reg_wdata[STAT_LANE*8 +: 8]),
      .ev_desc_irq_i  (ev_desc_irq),
      .ev_dev_frame_i (ev_dev_irq_frame),
      .dev_irq_dis_i  (dev_irq_disable),
      .ev_abort_i     (ev_bus_abort),
      .ev_start_set_i (ev_start_set),
      .ev_start_clr_i (ev_start_clr),
      .ev_eot_i       (ev_eot),
      .stat_o         (stat_q)
   );

   dcs_desc_ptr #(
      .W          (REG_W),
      .RESET_ZERO (PTR_RESET_ZERO)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr & hit_ptr),
      .be_i    (reg_be),
      .wdata_i (reg_wdata),
      .ptr_o   (ptr_q)
   );

   always_comb begin
      reg_rdata = '0;
      if (hit_stat)     reg_rdata[STAT_LANE*8 +: 8] = stat_q;
      else if (hit_ptr) reg_rdata = ptr_q;
   end

   assign status_o   = stat_q;
   assign desc_ptr_o = ptr_q;
   assign irq_o      = stat_q[B_DESC_IRQ] | stat_q[B_DEV_IRQ];
endmodule

// File: rtl/dma_chan_status_regs_chk.sv
module dma_chan_status_regs_chk #(
   parameter int ADDR_W     = 4,
   parameter int STAT_DWORD = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [3:0]        reg_be,
   input logic [31:0]       reg_wdata,
   input logic              ev_desc_irq,
   input logic              ev_eot,
   input logic              ev_bus_abort,
   input logic              ev_dev_irq_frame,
   input logic              dev_irq_disable,
   input logic              ev_start_set,
   input logic              ev_start_clr,
   input logic [7:0]        status_o,
   input logic [31:0]       desc_ptr_o,
   input logic              irq_o
);
   logic stat_zero_wr;
   assign stat_zero_wr = reg_wr && reg_be[2] && (reg_wdata[23:16] == 8'h00)
                         && (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(STAT_DWORD));

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[4:3] == 2'b00);                                      // R3
   AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      desc_ptr_o[1:0] == 2'b00);                                    // R8
   AST_DESC_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ev_desc_irq |=> (status_o[7] && irq_o));                      // R1
   AST_DEV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[2] && dev_irq_disable) |=> !status_o[2]);          // R4
   AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bus_abort |=> status_o[1]);                                // R5
   AST_START_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start_set && !ev_start_clr) |=> status_o[0]);             // R6
   AST_STOP_CLRS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start_clr |=> !status_o[0]);                               // R6
   AST_ACT_WRITE_PROOF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_start_set && !ev_start_clr && !ev_eot) |=> $stable(status_o[0])); // R6
   AST_ZERO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_zero_wr && !ev_desc_irq && !ev_dev_irq_frame && !ev_bus_abort)
      |=> $stable({status_o[7], status_o[2], status_o[1]}));        // R9
   AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[7] && !status_o[2]) |-> !irq_o);                   // R10
endmodule

bind dma_chan_status_regs dma_chan_status_regs_chk #(
   .ADDR_W     (ADDR_W),
   .STAT_DWORD (STAT_DWORD)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .reg_addr         (reg_addr),
   .reg_wr           (reg_wr),
   .reg_be           (reg_be),
   .reg_wdata        (reg_wdata),
   .ev_desc_irq      (ev_desc_irq),
   .ev_eot           (ev_eot),
   .ev_bus_abort     (ev_bus_abort),
   .ev_dev_irq_frame (ev_dev_irq_frame),
   .dev_irq_disable  (dev_irq_disable),
   .ev_start_set     (ev_start_set),
   .ev_start_clr     (ev_start_clr),
   .status_o         (status_o),
   .desc_ptr_o       (desc_ptr_o),
   .irq_o            (irq_o)
);

// File: tb/dma_chan_status_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_status_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ev_desc_irq = 0, ev_eot = 0, ev_bus_abort = 0, ev_dev_irq_frame = 0;
   logic        dev_irq_disable = 0, ev_start_set = 0, ev_start_clr = 0;
   logic [7:0]  status_o;
   logic [31:0] desc_ptr_o;
   logic        irq_o;

   int tests = 0;
   int fails = 0;
   logic [7:0]  m_stat = '0;
   logic [31:0] m_ptr = '0;

   always #2 clk = ~clk;

   dma_chan_status_regs u_dma_chan_status_regs (.*);

   // reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_stat = 8'h00;
         m_ptr  = 32'h0;
      end else begin
         logic swr;
         logic [7:0] wd;
         swr = reg_wr && reg_addr[3:2] == 2'd0 && reg_be[2];
         wd  = reg_wdata[23:16];
         if (ev_desc_irq) m_stat[7] = 1'b1;
         else if (swr && wd[7]) m_stat[7] = 1'b0;
         if (ev_dev_irq_frame && !dev_irq_disable) m_stat[2] = 1'b1;
         else if (swr && wd[2]) m_stat[2] = 1'b0;
         if (ev_bus_abort) m_stat[1] = 1'b1;
         else if (swr && wd[1]) m_stat[1] = 1'b0;
         if (swr) m_stat[6:5] = wd[6:5];
         if (ev_start_clr) m_stat[0] = 1'b0;
         else if (ev_start_set) m_stat[0] = 1'b1;
         else if (ev_eot) m_stat[0] = 1'b0;
         if (reg_wr && reg_addr[3:2] == 2'd1) begin
            for (int b = 0; b < 4; b++)
               if (reg_be[b]) m_ptr[b*8 +: 8] = reg_wdata[b*8 +: 8];
            m_ptr[1:0] = 2'b00;
         end
      end
   end

   function automatic logic [31:0] m_rd(input logic [3:0] a);
      case (a[3:2])
         2'd0:    return {8'h00, m_stat, 16'h0000};
         2'd1:    return m_ptr;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk(status_o[7] == m_stat[7], "R1 desc flag", 32'(status_o[7]), 32'(m_stat[7]));
      chk(status_o[6:5] == m_stat[6:5], "R2 cap bits", 32'(status_o[6:5]), 32'(m_stat[6:5]));
      chk(status_o[4:3] == 2'b00, "R3 reserved", 32'(status_o[4:3]), 32'h0);
      chk(status_o[2] == m_stat[2], "R4 dev flag", 32'(status_o[2]), 32'(m_stat[2]));
      chk(status_o[1] == m_stat[1], "R5 bus err", 32'(status_o[1]), 32'(m_stat[1]));
      chk(status_o[0] == m_stat[0], "R6 active", 32'(status_o[0]), 32'(m_stat[0]));
      chk(desc_ptr_o == m_ptr, "R8 pointer", desc_ptr_o, m_ptr);
      chk(irq_o == (m_stat[7] | m_stat[2]), "R10 irq", 32'(irq_o), 32'(m_stat[7] | m_stat[2]));
      chk(reg_rdata == m_rd(reg_addr), "R11 read", reg_rdata, m_rd(reg_addr));
   endtask

   task automatic idle();
      reg_wr = 0; reg_be = '0; reg_wdata = '0; reg_addr = '0;
      ev_desc_irq = 0; ev_eot = 0; ev_bus_abort = 0; ev_dev_irq_frame = 0;
      ev_start_set = 0; ev_start_clr = 0;
   endtask

   task automatic stat_write(input logic [7:0] v);
      reg_wr = 1; reg_addr = 4'h2; reg_be = 4'b0100; reg_wdata = {8'h00, v, 16'h0000};
   endtask

   task automatic step();
      @(negedge clk);
      check_all();
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset values
      chk(status_o == 8'h00, "R7 status reset", 32'(status_o), 32'h0);
      chk(desc_ptr_o == 32'h0, "R7 pointer reset", desc_ptr_o, 32'h0);
      // R9 set beats simultaneous clear
      ev_desc_irq = 1; stat_write(8'h80);
      step(); idle();
      chk(status_o[7] == 1'b1, "R9 set wins", 32'(status_o[7]), 32'h1);
      // R9 zero write keeps flag
      stat_write(8'h00);
      step(); idle();
      chk(status_o[7] == 1'b1, "R9 zero write", 32'(status_o[7]), 32'h1);
      // R1 write one clears
      stat_write(8'h80);
      step(); idle();
      chk(status_o[7] == 1'b0, "R1 w1c", 32'(status_o[7]), 32'h0);
      // R4 masked frame
      dev_irq_disable = 1; ev_dev_irq_frame = 1;
      step(); idle();
      chk(status_o[2] == 1'b0, "R4 masked", 32'(status_o[2]), 32'h0);
      dev_irq_disable = 0;
      // R6 write cannot set active; set beats eot
      stat_write(8'hFF);
      step(); idle();
      chk(status_o[0] == 1'b0, "R6 write ignored", 32'(status_o[0]), 32'h0);
      ev_start_set = 1; ev_eot = 1;
      step(); idle();
      chk(status_o[0] == 1'b1, "R6 set over eot", 32'(status_o[0]), 32'h1);
      // R8 partial byte-enable write
      reg_wr = 1; reg_addr = 4'h4; reg_be = 4'b1001; reg_wdata = 32'hA5A5_A5A7;
      step(); idle();
      chk(desc_ptr_o == 32'hA500_00A4, "R8 byte enables", desc_ptr_o, 32'hA500_00A4);
      // R11 status write without lane 2 enable
      reg_wr = 1; reg_addr = 4'h0; reg_be = 4'b1011; reg_wdata = 32'hFFFF_FFFF;
      step(); idle();
      chk(status_o[6:5] == 2'b11, "R11 lane gate", 32'(status_o[6:5]), 32'h3);
      // random phase
      for (int c = 0; c < 6000; c++) begin
         reg_wr           = ($urandom % 3) == 0;
         reg_addr         = 4'($urandom);
         reg_be           = 4'($urandom);
         reg_wdata        = $urandom;
         ev_desc_irq      = ($urandom % 6) == 0;
         ev_eot           = ($urandom % 6) == 0;
         ev_bus_abort     = ($urandom % 8) == 0;
         ev_dev_irq_frame = ($urandom % 5) == 0;
         dev_irq_disable  = ($urandom % 3) == 0;
         ev_start_set     = ($urandom % 6) == 0;
         ev_start_clr     = ($urandom % 7) == 0;
         step();
      end
      idle();
      step();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule